// File: doc/BRIEF.md
# Nonvolatile Command Unlock Detector

This block watches the stream of memory accesses, one registered strobe per chip-enable-controlled access. It looks for a fixed run of six consecutive read addresses. Five fixed prefix addresses, followed by one of two final addresses, unlock a nonvolatile save or restore command. When the run completes, the block raises a one-cycle request pulse. The pulse is `save_req` or `restore_req`, depending on the final address alone.

Any write access breaks the run. So does any read at an address other than the one expected next. Either one returns the detector to idle. The exception is a read at the first prefix address, which restarts the run at once as step 1. While the transfer engine reports busy, every access is ignored and the detector is held idle.

The block drives no memory data and does not time the nonvolatile transfer. The first five reads are ordinary reads, and the surrounding memory serves them.

Top module: `nvcmd_unlock`

## Requirements
- R1: After reset, the progress count is zero and both request outputs are low.
- R2: The prefix is 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0, read in that order. Each matching read advances the progress count (`seq_step`) by one, up to 5.
- R3: A read at 0x0F0F at step 5 pulses `save_req` high for exactly one cycle, the cycle after the strobe. The detector then returns to step 0.
- R4: A read at 0x0F0E at step 5 pulses `restore_req` high for exactly one cycle, the cycle after the strobe. The detector then returns to step 0.
- R5: Any access with `acc_wr_n` low (a write) returns the step to 0, and no request is issued.
- R6: A read at an address other than the expected one returns the step to 0. The exception is address 0x0000, which sets the step to 1.
- R7: A sixth read at an address other than the two command addresses returns the step to 0 with no pulse.
- R8: While `xfer_busy` is high, the step is forced to 0 and accesses have no effect.
- R9: Cycles without `acc_valid` leave the step unchanged.
- R10: `save_req` and `restore_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | One-cycle strobe per chip-enable-controlled access |
| acc_addr | input | 13 | Address of the access |
| acc_wr_n | input | 1 | Write-enable level: 1 means read, 0 means write |
| xfer_busy | input | 1 | The nonvolatile transfer is in progress |
| save_req | output | 1 | One-cycle save (STORE) request |
| restore_req | output | 1 | One-cycle restore (RECALL) request |
| seq_step | output | 3 | Number of prefix steps matched so far (0 to 5) |

## Verification
A corrupted progress state becomes visible on `seq_step` one cycle after the strobe that caused it. It also becomes visible as a missing or extra request pulse on the next step-5 access.

The bench therefore reads `seq_step` after every access. It checks every request output on each cycle of the command window. This exposes both a wrong transition and a pulse that lasts longer than one cycle.

// File: rtl/nvcmd_pkg.sv
package nvcmd_pkg;
    localparam int ADDR_W   = 13;
    localparam int PREFIX_N = 5;
    localparam int STEP_W   = $clog2(PREFIX_N + 1);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [STEP_W-1:0] step_t;

    typedef enum logic [1:0] {CMD_NONE, CMD_SAVE, CMD_RESTORE} cmd_e;

    localparam addr_t ADDR_SAVE    = 13'h0F0F;
    localparam addr_t ADDR_RESTORE = 13'h0F0E;

    function automatic addr_t prefix_addr(input step_t idx);
        case (idx)
            3'd0:    return 13'h0000;
            3'd1:    return 13'h1555;
            3'd2:    return 13'h0AAA;
            3'd3:    return 13'h1FFF;
            default: return 13'h10F0;
        endcase
    endfunction

    typedef struct packed {
        logic  valid;
        logic  rd;
        addr_t addr;
    } access_t;
endpackage

// File: rtl/nvcmd_match.sv
module nvcmd_match
    import nvcmd_pkg::*;
(
    input  access_t acc,
    input  step_t   step,
    output step_t   next_step,
    output cmd_e    cmd
);
    always_comb begin
        next_step = step;
        cmd       = CMD_NONE;
        if (acc.valid) begin
            if (!acc.rd) begin
                next_step = '0;
            end else if (step == step_t'(PREFIX_N)) begin
                next_step = '0;
                if (acc.addr == ADDR_SAVE)         cmd = CMD_SAVE;
                else if (acc.addr == ADDR_RESTORE) cmd = CMD_RESTORE;
                else if (acc.addr == prefix_addr('0)) next_step = step_t'(1);
            end else if (acc.addr == prefix_addr(step)) begin
                next_step = step + step_t'(1);
            end else if (acc.addr == prefix_addr('0)) begin
                next_step = step_t'(1);
            end else begin
                next_step = '0;
            end
        end
    end
endmodule

// File: rtl/nvcmd_unlock.sv
module nvcmd_unlock
    import nvcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_wr_n,
    input  logic              xfer_busy,
    output logic              save_req,
    output logic              restore_req,
    output logic [STEP_W-1:0] seq_step
);
    access_t acc;
    step_t   step_q, step_d;
    cmd_e    cmd;

    assign acc = '{valid: acc_valid, rd: acc_wr_n, addr: acc_addr};

    nvcmd_match u_match (.acc(acc), .step(step_q), .next_step(step_d), .cmd(cmd));

    always_ff @(posedge clk) begin
        if (rst || xfer_busy) begin
            step_q      <= '0;
            save_req    <= 1'b0;
            restore_req <= 1'b0;
        end else begin
            step_q      <= step_d;
            save_req    <= (cmd == CMD_SAVE);
            restore_req <= (cmd == CMD_RESTORE);
        end
    end

    assign seq_step = step_q;

    AST_REQ_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(save_req && restore_req)); // R10
    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (rst)
        step_q <= step_t'(PREFIX_N)); // R2
    AST_SAVE_PULSE: assert property (@(posedge clk) disable iff (rst)
        save_req |=> !save_req); // R3
    AST_RESTORE_PULSE: assert property (@(posedge clk) disable iff (rst)
        restore_req |=> !restore_req); // R4
    AST_WRITE_ABORT: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_wr_n) |=> (step_q == '0 && !save_req && !restore_req)); // R5
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        xfer_busy |=> (step_q == '0 && !save_req && !restore_req)); // R8
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!acc_valid && !xfer_busy) |=> $stable(step_q)); // R9
endmodule

// File: tb/nvcmd_unlock_test.sv
module nvcmd_unlock_test;
    logic        clk = 0, rst = 1;
    logic        acc_valid = 0, acc_wr_n = 1, xfer_busy = 0;
    logic [12:0] acc_addr = '0;
    logic        save_req, restore_req;
    logic [2:0]  seq_step;
    int total = 0, bad = 0;
    bit done = 0;

    nvcmd_unlock uut (.clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_wr_n(acc_wr_n), .xfer_busy(xfer_busy), .save_req(save_req),
        .restore_req(restore_req), .seq_step(seq_step));

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one access strobe for one cycle; sample at the following negedge.
    task automatic access(input logic [12:0] a, input logic rd);
        @(negedge clk);
        acc_valid = 1; acc_addr = a; acc_wr_n = rd;
        @(negedge clk);
        acc_valid = 0; acc_wr_n = 1;
    endtask

    task automatic prefix();
        access(13'h0000, 1); access(13'h1555, 1); access(13'h0AAA, 1);
        access(13'h1FFF, 1); access(13'h10F0, 1);
    endtask

    task automatic t_reset();
        chk("R1 step", seq_step, 0);
        chk("R1 save", save_req, 0);
        chk("R1 restore", restore_req, 0);
    endtask

    task automatic t_save();
        prefix();
        chk("R2 step5", seq_step, 5);
        access(13'h0F0F, 1);
        chk("R3 save pulse", save_req, 1);
        chk("R10 restore low", restore_req, 0);
        chk("R3 step0", seq_step, 0);
        @(negedge clk);
        chk("R3 one cycle", save_req, 0);
    endtask

    task automatic t_restore();
        prefix();
        access(13'h0F0E, 1);
        chk("R4 restore pulse", restore_req, 1);
        chk("R4 save low", save_req, 0);
        @(negedge clk);
        chk("R4 one cycle", restore_req, 0);
    endtask

    task automatic t_write();
        access(13'h0000, 1); access(13'h1555, 1);
        chk("R2 step2", seq_step, 2);
        access(13'h0AAA, 0);
        chk("R5 write abort", seq_step, 0);
        access(13'h1FFF, 1); access(13'h10F0, 1); access(13'h0F0F, 1);
        chk("R5 no pulse", save_req, 0);
    endtask

    task automatic t_wrong();
        access(13'h0000, 1); access(13'h1555, 1); access(13'h0123, 1);
        chk("R6 wrong addr", seq_step, 0);
        access(13'h0000, 1); access(13'h1555, 1); access(13'h0000, 1);
        chk("R6 restart", seq_step, 1);
        access(13'h1555, 1);
        chk("R6 continue", seq_step, 2);
        access(13'h0AAA, 1); access(13'h1FFF, 1); access(13'h10F0, 1);
        access(13'h0F0F, 1);
        chk("R6 save after restart", save_req, 1);
    endtask

    task automatic t_bad_sixth();
        prefix();
        access(13'h0F0D, 1);
        chk("R7 step", seq_step, 0);
        chk("R7 save", save_req, 0);
        chk("R7 restore", restore_req, 0);
    endtask

    task automatic t_busy();
        access(13'h0000, 1); access(13'h1555, 1);
        @(negedge clk); xfer_busy = 1;
        chk("R8 pre", seq_step, 2);
        access(13'h0AAA, 1);
        chk("R8 held", seq_step, 0);
        access(13'h0000, 1);
        chk("R8 ignored", seq_step, 0);
        xfer_busy = 0;
    endtask

    task automatic t_gap();
        access(13'h0000, 1); access(13'h1555, 1);
        repeat (4) @(negedge clk);
        chk("R9 stable", seq_step, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_save();
        t_restore();
        t_write();
        t_wrong();
        t_bad_sixth();
        t_busy();
        t_gap();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                bad++; total++;
                $display("FAIL watchdog actual=0 expected=1");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule